// File: doc/BRIEF.md
# Backup-Mode Switchover and Write-Protect Controller

This block chooses whether the memory supply rail is fed from the main supply or from the backup battery. It works from digitized samples: an external converter supplies the main-supply and battery voltages as unsigned millivolt codes together with a sample strobe. A separate flag says whether the main supply is below the reset threshold. The choice uses two thresholds, both measured relative to the battery. Moving onto the main supply needs a larger margin than staying on it, so a supply that sits close to the battery voltage does not make the rail chatter.

The block also forces every status output into a fixed backup-mode state while the rail is on the battery. The power-fail, low-line and reset outputs are driven to their asserted levels, and the watchdog output is held inactive. The watchdog strobe and the oscillator select seen by the downstream timing logic are frozen at their last values. A RAM chip-enable is passed through only while the supply is valid, so no write can land on memory when the supply is bad.

Every output is a flop, and all outputs move together on one clock edge. The registered backup-mode flag is also brought out so the watchdog and reset logic can use it.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: On a clock edge with `smp_vld` high and `main_mv >= batt_mv + 70`, the block leaves backup mode. From the next cycle `bkup_mode`=0 and `rail_main`=1.
- R2: On a clock edge with `smp_vld` high and `main_mv <= batt_mv + 50`, the block enters backup mode. This includes the case where `main_mv` is below `batt_mv`. From the next cycle `bkup_mode`=1 and `rail_main`=0.
- R3: The source selection changes only on edges with `smp_vld` high. A sample whose difference lies strictly between 50 and 70 mV keeps the current selection.
- R4: `batt_on` is 0 while the rail is on the main supply and 1 while it is on the battery. `batt_on` always equals `bkup_mode`.
- R5: In main mode with `below_thr`=0, `ce_n_out` equals the `ce_n_in` value of the previous cycle.
- R6: `ce_n_out` is 1 one cycle after any cycle in which `below_thr`=1 or the block is in backup mode, whatever the value of `ce_n_in`.
- R7: In backup mode, `pf_ok_out`=0, `line_ok_out`=0 and `rst_n_out`=0, and `pf_ok_in` has no effect. In main mode, `pf_ok_out` and `rst_n_out` follow `pf_ok_in` and `rst_n_in` with one cycle of delay.
- R8: In backup mode, `wdo_out`=1 whatever `wdo_in` is, and `wdi_out` and `osc_sel_out` hold the values they had when backup mode was entered. In main mode, `wdo_out`, `wdi_out` and `osc_sel_out` follow their inputs with one cycle of delay.
- R9: In main mode, `line_ok_out` is the inverse of the previous cycle's `below_thr`. It returns high on the first edge after `below_thr` clears.
- R10: While `rst` is high, and afterwards until the first sample selects the main supply, the outputs hold these values: `bkup_mode`=1, `rail_main`=0, `batt_on`=1, `ce_n_out`=1, `pf_ok_out`=0, `line_ok_out`=0, `rst_n_out`=0, `wdo_out`=1, `wdi_out`=0, `osc_sel_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Strobe marking a new voltage sample pair |
| main_mv | input | MV_W | Main supply voltage in mV |
| batt_mv | input | MV_W | Battery voltage in mV |
| below_thr | input | 1 | 1 when the main supply is below the reset threshold |
| ce_n_in | input | 1 | Active-low RAM chip-enable from the address decoder |
| pf_ok_in | input | 1 | Raw power-fail comparator result, 1 = healthy |
| rst_n_in | input | 1 | Active-low reset from the reset pulse generator |
| wdo_in | input | 1 | Watchdog expiry output from the timer, 0 = expired |
| wdi_in | input | 1 | Watchdog service strobe from the processor |
| osc_sel_in | input | 1 | Oscillator source select request |
| rail_main | output | 1 | Power-path select, 1 = rail on main supply |
| batt_on | output | 1 | 1 while the rail is fed from the battery |
| ce_n_out | output | 1 | Gated active-low chip-enable to the RAM |
| pf_ok_out | output | 1 | Power-fail status, 0 = warning |
| line_ok_out | output | 1 | Low-line status, 0 = supply low |
| rst_n_out | output | 1 | Active-low processor reset |
| wdo_out | output | 1 | Watchdog status, 0 = expired |
| wdi_out | output | 1 | Watchdog strobe as seen by the timer |
| osc_sel_out | output | 1 | Oscillator select as seen by the timing logic |
| bkup_mode | output | 1 | Registered backup-mode flag |

## Verification
A wrong hysteresis comparison or a wrong mode register shows up one cycle after the offending sample. It appears as `rail_main`, `batt_on` and `bkup_mode` all flipping the wrong way together, so the samples exactly at 50 mV and 70 mV and the samples one millivolt inside them are the decisive stimuli. A gating fault appears as a chip-enable low, or a status output at its main-mode value, on the first cycle after a backup sample or a low-threshold flag. A missing hold on the watchdog strobe or the oscillator select appears only when those inputs toggle during backup mode, and that again takes one cycle.

// File: rtl/bkup_pkg.sv
package bkup_pkg;

    // Rail source selection
    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_BATT = 1'b1
    } src_t;

    // Default switchover margins (millivolts above the battery)
    localparam int unsigned UP_MARGIN_DEF = 70;
    localparam int unsigned DN_MARGIN_DEF = 50;

    // Raw inputs that the gating stage qualifies
    typedef struct packed {
        logic below;
        logic ce_n;
        logic pf_ok;
        logic rst_n;
        logic wdo;
        logic wdi;
        logic osc_sel;
    } gate_in_t;

    // Registered output bundle
    typedef struct packed {
        logic rail_main;
        logic batt_on;
        logic ce_n;
        logic pf_ok;
        logic line_ok;
        logic rst_n;
        logic wdo;
        logic wdi;
        logic osc_sel;
    } gate_out_t;

    // Output values forced while on battery; the held watchdog strobe and
    // oscillator select are supplied by the caller
    function automatic gate_out_t backup_values(logic hold_wdi, logic hold_osc);
        gate_out_t o;
        o.rail_main = 1'b0;
        o.batt_on   = 1'b1;
        o.ce_n      = 1'b1;
        o.pf_ok     = 1'b0;
        o.line_ok   = 1'b0;
        o.rst_n     = 1'b0;
        o.wdo       = 1'b1;
        o.wdi       = hold_wdi;
        o.osc_sel   = hold_osc;
        return o;
    endfunction

    // Output values while the rail is on the main supply
    function automatic gate_out_t main_values(gate_in_t gi);
        gate_out_t o;
        o.rail_main = 1'b1;
        o.batt_on   = 1'b0;
        o.ce_n      = gi.below ? 1'b1 : gi.ce_n;
        o.pf_ok     = gi.pf_ok;
        o.line_ok   = ~gi.below;
        o.rst_n     = gi.rst_n;
        o.wdo       = gi.wdo;
        o.wdi       = gi.wdi;
        o.osc_sel   = gi.osc_sel;
        return o;
    endfunction

endpackage

// File: rtl/bkup_path_sel.sv
module bkup_path_sel
    import bkup_pkg::*;
#(
    parameter int unsigned MV_W      = 16,
    parameter int unsigned UP_MARGIN = UP_MARGIN_DEF,
    parameter int unsigned DN_MARGIN = DN_MARGIN_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_vld,
    input  logic [MV_W-1:0] main_mv,
    input  logic [MV_W-1:0] batt_mv,
    output src_t            src_nxt,
    output src_t            src_q
);
    // One extra bit so battery + margin cannot wrap
    localparam int unsigned SUM_W = MV_W + 1;
    localparam logic [SUM_W-1:0] UP_ADD = SUM_W'(UP_MARGIN);
    localparam logic [SUM_W-1:0] DN_ADD = SUM_W'(DN_MARGIN);

    logic [SUM_W-1:0] main_ext;
    logic [SUM_W-1:0] up_lvl;
    logic [SUM_W-1:0] dn_lvl;
    logic             go_main;
    logic             go_batt;

    always_comb begin
        main_ext = {1'b0, main_mv};
        up_lvl   = {1'b0, batt_mv} + UP_ADD;
        dn_lvl   = {1'b0, batt_mv} + DN_ADD;
        go_main  = main_ext >= up_lvl;
        go_batt  = main_ext <= dn_lvl;
    end

    // Decision taken only on the strobe; the dead band keeps the state
    always_comb begin
        src_nxt = src_q;
        if (smp_vld) begin
            if (go_batt)
                src_nxt = SRC_BATT;
            else if (go_main)
                src_nxt = SRC_MAIN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            src_q <= SRC_BATT;
        else
            src_q <= src_nxt;
    end

endmodule

// File: rtl/bkup_out_gate.sv
module bkup_out_gate
    import bkup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_t      src_nxt,
    input  gate_in_t  gin,
    output gate_out_t gout
);
    gate_out_t nxt;

    // Outputs are computed from the next source so that they move on the
    // same edge as the mode flag
    always_comb begin
        if (src_nxt == SRC_BATT)
            nxt = backup_values(gout.wdi, gout.osc_sel);
        else
            nxt = main_values(gin);
    end

    always_ff @(posedge clk) begin
        if (rst)
            gout <= backup_values(1'b0, 1'b1);
        else
            gout <= nxt;
    end

endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
    import bkup_pkg::*;
#(
    parameter int unsigned MV_W      = 16,
    parameter int unsigned UP_MARGIN = UP_MARGIN_DEF,
    parameter int unsigned DN_MARGIN = DN_MARGIN_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_vld,
    input  logic [MV_W-1:0] main_mv,
    input  logic [MV_W-1:0] batt_mv,
    input  logic            below_thr,
    input  logic            ce_n_in,
    input  logic            pf_ok_in,
    input  logic            rst_n_in,
    input  logic            wdo_in,
    input  logic            wdi_in,
    input  logic            osc_sel_in,
    output logic            rail_main,
    output logic            batt_on,
    output logic            ce_n_out,
    output logic            pf_ok_out,
    output logic            line_ok_out,
    output logic            rst_n_out,
    output logic            wdo_out,
    output logic            wdi_out,
    output logic            osc_sel_out,
    output logic            bkup_mode
);
    src_t      src_nxt;
    src_t      src_q;
    gate_in_t  gin;
    gate_out_t gout;

    bkup_path_sel #(
        .MV_W      (MV_W),
        .UP_MARGIN (UP_MARGIN),
        .DN_MARGIN (DN_MARGIN)
    ) u_path (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .main_mv (main_mv),
        .batt_mv (batt_mv),
        .src_nxt (src_nxt),
        .src_q   (src_q)
    );

    always_comb begin
        gin.below   = below_thr;
        gin.ce_n    = ce_n_in;
        gin.pf_ok   = pf_ok_in;
        gin.rst_n   = rst_n_in;
        gin.wdo     = wdo_in;
        gin.wdi     = wdi_in;
        gin.osc_sel = osc_sel_in;
    end

    bkup_out_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .src_nxt (src_nxt),
        .gin     (gin),
        .gout    (gout)
    );

    assign bkup_mode   = (src_q == SRC_BATT);
    assign rail_main   = gout.rail_main;
    assign batt_on     = gout.batt_on;
    assign ce_n_out    = gout.ce_n;
    assign pf_ok_out   = gout.pf_ok;
    assign line_ok_out = gout.line_ok;
    assign rst_n_out   = gout.rst_n;
    assign wdo_out     = gout.wdo;
    assign wdi_out     = gout.wdi;
    assign osc_sel_out = gout.osc_sel;

endmodule

// File: rtl/bkup_switch_chk.sv
module bkup_switch_chk #(
    parameter int unsigned MV_W      = 16,
    parameter int unsigned UP_MARGIN = 70,
    parameter int unsigned DN_MARGIN = 50
) (
    input logic            clk,
    input logic            rst,
    input logic            smp_vld,
    input logic [MV_W-1:0] main_mv,
    input logic [MV_W-1:0] batt_mv,
    input logic            below_thr,
    input logic            rail_main,
    input logic            batt_on,
    input logic            ce_n_out,
    input logic            pf_ok_out,
    input logic            line_ok_out,
    input logic            rst_n_out,
    input logic            wdo_out,
    input logic            wdi_out,
    input logic            osc_sel_out,
    input logic            bkup_mode
);
    logic [MV_W:0] m_ext;
    logic [MV_W:0] b_up;
    logic [MV_W:0] b_dn;
    assign m_ext = {1'b0, main_mv};
    assign b_up  = {1'b0, batt_mv} + (MV_W+1)'(UP_MARGIN);
    assign b_dn  = {1'b0, batt_mv} + (MV_W+1)'(DN_MARGIN);

    // R1
    to_main_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && m_ext >= b_up && m_ext > b_dn) |=> (!bkup_mode && rail_main));

    // R2
    to_batt_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && m_ext <= b_dn) |=> (bkup_mode && !rail_main));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(bkup_mode));

    // R4
    batt_on_chk: assert property (@(posedge clk) disable iff (rst)
        (batt_on == bkup_mode) && (rail_main != batt_on));

    // R6
    ce_block_chk: assert property (@(posedge clk) disable iff (rst)
        below_thr |=> ce_n_out);

    // R6
    ce_bkup_chk: assert property (@(posedge clk) disable iff (rst)
        bkup_mode |-> ce_n_out);

    // R7
    status_force_chk: assert property (@(posedge clk) disable iff (rst)
        bkup_mode |-> (!pf_ok_out && !line_ok_out && !rst_n_out));

    // R8
    wdo_force_chk: assert property (@(posedge clk) disable iff (rst)
        bkup_mode |-> wdo_out);

    // R8
    wdi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bkup_mode && $past(bkup_mode)) |-> ($stable(wdi_out) && $stable(osc_sel_out)));

endmodule

bind bkup_switch_ctrl bkup_switch_chk #(
    .MV_W      (MV_W),
    .UP_MARGIN (UP_MARGIN),
    .DN_MARGIN (DN_MARGIN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_vld     (smp_vld),
    .main_mv     (main_mv),
    .batt_mv     (batt_mv),
    .below_thr   (below_thr),
    .rail_main   (rail_main),
    .batt_on     (batt_on),
    .ce_n_out    (ce_n_out),
    .pf_ok_out   (pf_ok_out),
    .line_ok_out (line_ok_out),
    .rst_n_out   (rst_n_out),
    .wdo_out     (wdo_out),
    .wdi_out     (wdi_out),
    .osc_sel_out (osc_sel_out),
    .bkup_mode   (bkup_mode)
);

// File: tb/sim_bkup_switch_ctrl.sv
module sim_bkup_switch_ctrl;
    localparam int MV_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0;
    logic [MV_W-1:0] main_mv = '0;
    logic [MV_W-1:0] batt_mv = '0;
    logic below_thr = 1'b0;
    logic ce_n_in = 1'b1;
    logic pf_ok_in = 1'b1;
    logic rst_n_in = 1'b1;
    logic wdo_in = 1'b1;
    logic wdi_in = 1'b0;
    logic osc_sel_in = 1'b1;
    logic rail_main, batt_on, ce_n_out, pf_ok_out, line_ok_out;
    logic rst_n_out, wdo_out, wdi_out, osc_sel_out, bkup_mode;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    bkup_switch_ctrl #(.MV_W(MV_W)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .main_mv(main_mv), .batt_mv(batt_mv), .below_thr(below_thr),
        .ce_n_in(ce_n_in), .pf_ok_in(pf_ok_in), .rst_n_in(rst_n_in),
        .wdo_in(wdo_in), .wdi_in(wdi_in), .osc_sel_in(osc_sel_in),
        .rail_main(rail_main), .batt_on(batt_on), .ce_n_out(ce_n_out),
        .pf_ok_out(pf_ok_out), .line_ok_out(line_ok_out),
        .rst_n_out(rst_n_out), .wdo_out(wdo_out), .wdi_out(wdi_out),
        .osc_sel_out(osc_sel_out), .bkup_mode(bkup_mode)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present a sample for exactly one edge, then sample after that edge
    task automatic sample(input int m, input int b);
        main_mv = MV_W'(m);
        batt_mv = MV_W'(b);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic chk_mode(input string req, input logic exp_bk);
        chk(req, "bkup_mode", {31'd0, bkup_mode}, {31'd0, exp_bk});
        chk(req, "rail_main", {31'd0, rail_main}, {31'd0, ~exp_bk});
        chk(req, "batt_on",   {31'd0, batt_on},   {31'd0, exp_bk});
    endtask

    task automatic t_reset();
        // R10: backup values during reset and before the first sample
        ce_n_in = 1'b0; pf_ok_in = 1'b1; rst_n_in = 1'b1; wdo_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "bkup in reset", {31'd0, bkup_mode}, 32'd1);
        rst = 1'b0;
        main_mv = 16'd3300; batt_mv = 16'd2400;
        repeat (3) @(negedge clk);
        chk_mode("R10", 1'b1);
        chk("R10", "ce_n_out",    {31'd0, ce_n_out},    32'd1);
        chk("R10", "pf_ok_out",   {31'd0, pf_ok_out},   32'd0);
        chk("R10", "line_ok_out", {31'd0, line_ok_out}, 32'd0);
        chk("R10", "rst_n_out",   {31'd0, rst_n_out},   32'd0);
        chk("R10", "wdo_out",     {31'd0, wdo_out},     32'd1);
        chk("R10", "wdi_out",     {31'd0, wdi_out},     32'd0);
        chk("R10", "osc_sel_out", {31'd0, osc_sel_out}, 32'd1);
    endtask

    task automatic t_thresholds();
        // R3: 69 mV above battery from backup mode keeps battery
        sample(2469, 2400);
        chk_mode("R3", 1'b1);
        // R1: exactly 70 mV above switches to main
        sample(2470, 2400);
        chk_mode("R1", 1'b0);
        // R3: 51 mV keeps main
        sample(2451, 2400);
        chk_mode("R3", 1'b0);
        // R2: exactly 50 mV switches to battery
        sample(2450, 2400);
        chk_mode("R2", 1'b1);
        // R3: large margin without strobe has no effect
        main_mv = 16'd3300;
        repeat (3) @(negedge clk);
        chk_mode("R3", 1'b1);
        sample(3300, 2400);
        chk_mode("R1", 1'b0);
        // R2: main below battery
        sample(1000, 2400);
        chk_mode("R2", 1'b1);
        sample(3300, 2400);
        chk_mode("R1", 1'b0);
    endtask

    task automatic t_ce_gate();
        // R5: pass-through in main mode with valid supply
        below_thr = 1'b0;
        ce_n_in = 1'b0;
        @(negedge clk);
        chk("R5", "ce_n_out low", {31'd0, ce_n_out}, 32'd0);
        ce_n_in = 1'b1;
        @(negedge clk);
        chk("R5", "ce_n_out high", {31'd0, ce_n_out}, 32'd1);
        // R6: below threshold blocks
        ce_n_in = 1'b0;
        below_thr = 1'b1;
        @(negedge clk);
        chk("R6", "ce_n below thr", {31'd0, ce_n_out}, 32'd1);
        // R9: low-line follows the threshold flag
        chk("R9", "line_ok low", {31'd0, line_ok_out}, 32'd0);
        below_thr = 1'b0;
        @(negedge clk);
        chk("R9", "line_ok back", {31'd0, line_ok_out}, 32'd1);
        chk("R5", "ce_n resumes", {31'd0, ce_n_out}, 32'd0);
        // R6: battery mode blocks
        sample(2000, 2400);
        chk("R6", "ce_n in backup", {31'd0, ce_n_out}, 32'd1);
        sample(3300, 2400);
        chk("R5", "ce_n after return", {31'd0, ce_n_out}, 32'd0);
    endtask

    task automatic t_status();
        // R7: main mode follows inputs
        pf_ok_in = 1'b0; rst_n_in = 1'b0;
        @(negedge clk);
        chk("R7", "pf_ok follows", {31'd0, pf_ok_out}, 32'd0);
        chk("R7", "rst_n follows", {31'd0, rst_n_out}, 32'd0);
        pf_ok_in = 1'b1; rst_n_in = 1'b1;
        @(negedge clk);
        chk("R7", "pf_ok follows hi", {31'd0, pf_ok_out}, 32'd1);
        chk("R7", "rst_n follows hi", {31'd0, rst_n_out}, 32'd1);
        // R7: backup forces, power-fail input ignored
        sample(2300, 2400);
        chk("R7", "pf_ok forced", {31'd0, pf_ok_out}, 32'd0);
        chk("R7", "line_ok forced", {31'd0, line_ok_out}, 32'd0);
        chk("R7", "rst_n forced", {31'd0, rst_n_out}, 32'd0);
        pf_ok_in = 1'b0;
        @(negedge clk);
        pf_ok_in = 1'b1;
        @(negedge clk);
        chk("R7", "pf_ok ignored", {31'd0, pf_ok_out}, 32'd0);
        sample(3300, 2400);
    endtask

    task automatic t_wdog();
        // R8: main mode follows
        wdi_in = 1'b1; osc_sel_in = 1'b0; wdo_in = 1'b0;
        @(negedge clk);
        chk("R8", "wdi follows", {31'd0, wdi_out}, 32'd1);
        chk("R8", "osc follows", {31'd0, osc_sel_out}, 32'd0);
        chk("R8", "wdo follows", {31'd0, wdo_out}, 32'd0);
        // R8: backup holds and forces
        sample(2400, 2400);
        chk("R8", "wdo forced", {31'd0, wdo_out}, 32'd1);
        wdi_in = 1'b0; osc_sel_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "wdi held", {31'd0, wdi_out}, 32'd1);
        chk("R8", "osc held", {31'd0, osc_sel_out}, 32'd0);
        chk("R8", "wdo still forced", {31'd0, wdo_out}, 32'd1);
        sample(3300, 2400);
        chk("R8", "wdi resumes", {31'd0, wdi_out}, 32'd0);
        chk("R8", "osc resumes", {31'd0, osc_sel_out}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_thresholds();
        t_ce_gate();
        t_status();
        t_wdog();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule